// File: doc/BRIEF.md
# Lockstep Mealy Equivalence Monitor

This block runs two small Mealy machines in lockstep on one serial bit stream and reports, on every step, whether they produce the same output. The first machine counts consecutive ones and saturates after two. The second counts consecutive ones and saturates after three. Both fire when the current bit is a one and at least two ones came directly before it. Together the two state registers form one product state. The block compares the two machine outputs for the current bit in that product state.

Input bits arrive on a valid/ready stream. The block applies no back-pressure: `in_ready` is low only while reset is held, and every other cycle with `in_valid` high is an accepted step. The outputs are Mealy outputs. They are combinational in the current product state and `in_bit`, so `in_bit` must be stable before the sampling edge. A sticky flag records any accepted step on which the machines disagreed.

Top module: `lockstep_eq_mon`

## Requirements
- R1: A synchronous reset puts both machines in their start states and clears `mismatch_seen`. After reset, `in_bit`=1 gives `out_a`=0 and `out_b`=0.
- R2: Machine A has states 0, 1 and 2, and 0 is the start state. On an accepted step, a 0 bit sends it to state 0. A 1 bit advances it by one state, and it stays at state 2 once there.
- R3: `out_a` is 1 exactly when machine A is in state 2 and `in_bit` is 1.
- R4: Machine B has states 0, 1, 2 and 3, and 0 is the start state. On an accepted step, a 0 bit sends it to state 0. A 1 bit advances it by one state, and it stays at state 3 once there.
- R5: `out_b` is 1 exactly when machine B is in state 2 or state 3 and `in_bit` is 1.
- R6: `agree` is 1 when `out_a` equals `out_b`, and 0 otherwise. It responds in the same cycle as `in_bit`.
- R7: Both state registers change only on a clock edge where `in_valid` and `in_ready` are both high. On any other edge they hold, whatever `in_bit` is.
- R8: `mismatch_seen` becomes 1 after an accepted step with `agree`=0. After that, only reset clears it. With the two fixed machines it stays 0 for every input stream.
- R9: `in_ready` is 0 while `rst` is high and 1 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit is offered this cycle |
| in_ready | output | 1 | Block accepts a bit this cycle |
| in_bit | input | 1 | Serial input bit |
| out_a | output | 1 | Mealy output of machine A |
| out_b | output | 1 | Mealy output of machine B |
| agree | output | 1 | Both machine outputs are equal |
| mismatch_seen | output | 1 | Sticky record of a disagreeing accepted step |

## Verification
The properties assume `in_valid` and `in_bit` are stable around each rising edge. They also assume that a step only counts when `rst` is low. The bench meets both conditions by changing inputs only on the falling edge and by holding `in_valid` low while reset is asserted. Through a bound checker, the properties watch the two state registers directly. Idle cycles in the bench carry arbitrary `in_bit` values, so the hold rule is exercised with real data rather than only with zeros.

// File: rtl/lockstep_eq_pkg.sv
package lockstep_eq_pkg;
  // Highest state index of each run-length machine and the index from which
  // a 1 bit makes it fire.
  localparam int unsigned A_LAST_DEF = 2;
  localparam int unsigned A_FIRE_DEF = 2;
  localparam int unsigned B_LAST_DEF = 3;
  localparam int unsigned B_FIRE_DEF = 2;

  typedef struct packed {
    logic a;
    logic b;
  } fire_pair_t;
endpackage

// File: rtl/run_mealy.sv
module run_mealy #(
  parameter int unsigned LAST = 2,
  parameter int unsigned FIRE = 2,
  parameter int unsigned SW   = $clog2(LAST + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          bit_i,
  output logic [SW-1:0] state_q,
  output logic          fire
);
  localparam logic [SW-1:0] TOP_ST  = SW'(LAST);
  localparam logic [SW-1:0] FIRE_ST = SW'(FIRE);

  logic [SW-1:0] state_d;

  always_comb begin
    if (!bit_i)                state_d = '0;
    else if (state_q == TOP_ST) state_d = state_q;
    else                       state_d = state_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       state_q <= '0;
    else if (step) state_q <= state_d;
  end

  assign fire = bit_i && (state_q >= FIRE_ST);
endmodule

// File: rtl/agree_tracker.sv
module agree_tracker
  import lockstep_eq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  fire_pair_t fires,
  output logic       agree,
  output logic       mismatch_q
);
  assign agree = (fires.a == fires.b);

  always_ff @(posedge clk) begin
    if (rst)                mismatch_q <= 1'b0;
    else if (step && !agree) mismatch_q <= 1'b1;
  end
endmodule

// File: rtl/lockstep_eq_mon.sv
module lockstep_eq_mon
  import lockstep_eq_pkg::*;
#(
  parameter int unsigned A_LAST = A_LAST_DEF,
  parameter int unsigned A_FIRE = A_FIRE_DEF,
  parameter int unsigned B_LAST = B_LAST_DEF,
  parameter int unsigned B_FIRE = B_FIRE_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_a,
  output logic out_b,
  output logic agree,
  output logic mismatch_seen
);
  localparam int unsigned AW = $clog2(A_LAST + 1);
  localparam int unsigned BW = $clog2(B_LAST + 1);

  logic          take;
  logic [AW-1:0] a_q;
  logic [BW-1:0] b_q;
  fire_pair_t    fires;

  assign in_ready = !rst;
  assign take     = in_valid && in_ready;

  run_mealy #(.LAST(A_LAST), .FIRE(A_FIRE), .SW(AW)) u_mach_a (
    .clk(clk), .rst(rst), .step(take), .bit_i(in_bit),
    .state_q(a_q), .fire(fires.a)
  );

  run_mealy #(.LAST(B_LAST), .FIRE(B_FIRE), .SW(BW)) u_mach_b (
    .clk(clk), .rst(rst), .step(take), .bit_i(in_bit),
    .state_q(b_q), .fire(fires.b)
  );

  agree_tracker u_cmp (
    .clk(clk), .rst(rst), .step(take), .fires(fires),
    .agree(agree), .mismatch_q(mismatch_seen)
  );

  assign out_a = fires.a;
  assign out_b = fires.b;
endmodule

// File: rtl/lockstep_eq_chk.sv
module lockstep_eq_chk #(
  parameter int unsigned A_LAST = 2,
  parameter int unsigned B_LAST = 3,
  parameter int unsigned AW = 2,
  parameter int unsigned BW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_bit,
  input logic          out_a,
  input logic          out_b,
  input logic          agree,
  input logic          mismatch_seen,
  input logic [AW-1:0] a_q,
  input logic [BW-1:0] b_q
);
  assert_a_range_R2: assert property (@(posedge clk) disable iff (rst)
    a_q <= AW'(A_LAST));

  assert_zero_clears_R2_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_bit) |=> (a_q == '0 && b_q == '0));

  assert_b_saturates_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_bit && b_q == BW'(B_LAST)) |=> (b_q == BW'(B_LAST)));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(a_q) && $stable(b_q)));

  assert_a_implies_b_R6: assert property (@(posedge clk) disable iff (rst)
    out_a |-> (out_b && agree));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    mismatch_seen |=> mismatch_seen);

  assert_no_mismatch_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> agree);
endmodule

bind lockstep_eq_mon lockstep_eq_chk #(
  .A_LAST(A_LAST), .B_LAST(B_LAST), .AW(AW), .BW(BW)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
  .out_a(out_a), .out_b(out_b), .agree(agree), .mismatch_seen(mismatch_seen),
  .a_q(a_q), .b_q(b_q)
);

// File: tb/lockstep_eq_mon_test.sv
module lockstep_eq_mon_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready, out_a, out_b, agree, mismatch_seen;

  int checks = 0;
  int fails  = 0;
  int ma = 0;
  int mb = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lockstep_eq_mon uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_a(out_a), .out_b(out_b), .agree(agree),
    .mismatch_seen(mismatch_seen)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b (ma=%0d mb=%0d)", req, act, exp, ma, mb);
    end
  endtask

  // One cycle: drive on the falling edge, check the Mealy outputs, then let
  // the rising edge advance the reference counters if the step is taken.
  task automatic step(input logic v, input logic b);
    logic ea, eb;
    @(negedge clk);
    in_valid = v;
    in_bit = b;
    #1;
    ea = b && (ma >= 2);
    eb = b && (mb >= 2);
    chk("R3", out_a, ea);
    chk("R5", out_b, eb);
    chk("R6", agree, ea == eb);
    chk("R8", mismatch_seen, 1'b0);
    chk("R9", in_ready, 1'b1);
    if (v) begin
      ma = b ? ((ma < 2) ? ma + 1 : 2) : 0;   // R2
      mb = b ? ((mb < 3) ? mb + 1 : 3) : 0;   // R4
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    in_bit = 1'b1;
    #1;
    chk("R9", in_ready, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    ma = 0;
    mb = 0;
    #1;
    chk("R1", out_a, 1'b0);
    chk("R1", out_b, 1'b0);
    chk("R1", mismatch_seen, 1'b0);
  endtask

  task automatic run_seq(input logic [15:0] s, input int n);
    for (int i = n - 1; i >= 0; i--) step(1'b1, s[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    // Given sequences, msb first.
    run_seq(16'b101110, 6);
    do_reset();
    run_seq(16'b01011, 5);
    // Long run of ones: A saturates at 2, B at 3 (R2, R4).
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1);
    // R7: idle cycles with changing bits must not move the state.
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b0, i[0]);
    step(1'b1, 1'b1); // both fire only if state was held at 2
    // R1: reset from a saturated state.
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    do_reset();
    step(1'b1, 1'b1);
    // Exhaustive sweep over all 9-bit streams with idle gaps interleaved.
    for (int p = 0; p < 512; p++) begin
      do_reset();
      for (int k = 8; k >= 0; k--) begin
        if (((p + k) % 5) == 3) step(1'b0, ~p[k]);
        step(1'b1, p[k]);
      end
    end
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_800_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule